// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block carries out the architectural side effects of entering an exception handler, all in one clock edge. A core presents a one-cycle request strobe together with a 4-bit exception type code, the address of the faulting instruction, the address of the following instruction, the live machine state word, the live timer status word and a faulting data address. On that edge the block saves the return context and writes a masked machine state word that depends on the exception class. Where the class calls for it, it also records the faulting data address or raises the decrementer flag in the timer status word. It then latches the handler entry address. One cycle later it pulses either `done_o` or, for a type it does not serve, `err_o`. When it raises `err_o` it leaves every output register untouched.

The handler address is formed from two parts. The upper half of a vector prefix register supplies the high bits. A 16-entry offset table, indexed by the type code, supplies bits 15:4. Both are loaded through plain write ports. The control is a three-state machine. `ST_IDLE` waits. `ST_DONE` drives `done_o`. `ST_ERR` drives `err_o`. From any state, a request moves the machine to `ST_DONE` when the type is served and to `ST_ERR` when it is not. A cycle without a request moves it to `ST_IDLE`. Consecutive requests are therefore accepted on consecutive cycles.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `srr0_o`, `srr1_o`, `msr_o`, `tsr_o`, `dear_o` and `handler_o` read zero, `done_o` and `err_o` are low, and the vector prefix and every offset table entry hold zero.
- R2: Type 4 (external interrupt) and type 10 (decrementer) load `srr0_o` with `next_pc_i`, load `srr1_o` with `msr_i`, and load `msr_o` with `msr_i & 32'h00021200`.
- R3: Type 8 (system call) loads `srr0_o` with `next_pc_i`, loads `srr1_o` with `msr_i`, and loads `msr_o` with `msr_i & ~32'h0002E930`.
- R4: Type 10 loads `tsr_o` with `tsr_i | 32'h08000000` (bit 27 set). The other served types leave `tsr_o` unchanged.
- R5: Type 13 (data TLB miss) loads `srr0_o` with `cur_pc_i`, `srr1_o` with `msr_i`, `dear_o` with `fault_addr_i`, and `msr_o` with `msr_i & 32'h00021200`. The other served types leave `dear_o` unchanged.
- R6: A served request loads `handler_o` with {prefix[31:16], offset[type][15:4], 4'b0000}, where prefix is the last value written through the prefix port.
- R7: Every type code other than 4, 8, 10 and 13 raises `err_o` for exactly one cycle, in the cycle after the request. All six output registers keep their values.
- R8: A served request raises `done_o` for exactly one cycle, in the cycle after the request. `done_o` and `err_o` are never high together, and neither is high without a request on the previous edge.
- R9: `ivor_we_i` writes `ivor_wdata_i` into offset entry `ivor_idx_i`, and `ivpr_we_i` writes the prefix. A later request of that type uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle exception request strobe |
| type_i | input | 4 | Exception type code |
| cur_pc_i | input | 32 | Address of the faulting instruction |
| next_pc_i | input | 32 | Address of the following instruction |
| msr_i | input | 32 | Live machine state word |
| tsr_i | input | 32 | Live timer status word |
| fault_addr_i | input | 32 | Faulting data address |
| ivpr_we_i | input | 1 | Vector prefix write enable |
| ivpr_wdata_i | input | 32 | Vector prefix write data |
| ivor_we_i | input | 1 | Offset table write enable |
| ivor_idx_i | input | 4 | Offset table write index |
| ivor_wdata_i | input | 32 | Offset table write data |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved machine state word |
| msr_o | output | 32 | New machine state word |
| tsr_o | output | 32 | Timer status word after entry |
| dear_o | output | 32 | Recorded faulting data address |
| handler_o | output | 32 | Handler entry address |
| done_o | output | 1 | Entry completed pulse |
| err_o | output | 1 | Unsupported type pulse |

## Verification
A misdecoded type class appears in the cycle after the request. The mask on `msr_o` is wrong, `srr0_o` holds the wrong one of the two PCs, or the wrong one of `done_o` and `err_o` pulses. A corrupted offset table entry or prefix stays hidden until a request of that type arrives, and then shows in `handler_o` on the same following cycle. A state machine stuck in `ST_DONE` or `ST_ERR` shows as a pulse longer than one cycle, or as a pulse with no request before it. A missing pulse leaves the scoreboard queue non-empty at the end of the run.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam logic [3:0] TYPE_EXT_IRQ = 4'd4;
    localparam logic [3:0] TYPE_SYSCALL = 4'd8;
    localparam logic [3:0] TYPE_DECR    = 4'd10;
    localparam logic [3:0] TYPE_DTLB    = 4'd13;

    localparam logic [31:0] MSR_KEEP_MASK = 32'h0002_1200;
    localparam logic [31:0] MSR_SC_CLEAR  = 32'h0002_E930;
    localparam logic [31:0] TSR_DECR_FLAG = 32'h0800_0000;

    typedef enum logic [1:0] {
        CLS_ASYNC,
        CLS_SYSCALL,
        CLS_DTLB,
        CLS_NONE
    } exc_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DONE,
        ST_ERR
    } seq_state_e;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_entry_pkg::*;
#(
    parameter int unsigned TYPE_W = 4
) (
    input  logic [TYPE_W-1:0] type_i,
    output exc_class_e        cls_o,
    output logic              timer_o
);
    always_comb begin
        cls_o   = CLS_NONE;
        timer_o = 1'b0;
        case (4'(type_i))
            TYPE_EXT_IRQ: cls_o = CLS_ASYNC;
            TYPE_DECR: begin
                cls_o   = CLS_ASYNC;
                timer_o = 1'b1;
            end
            TYPE_SYSCALL: cls_o = CLS_SYSCALL;
            TYPE_DTLB:    cls_o = CLS_DTLB;
            default:      cls_o = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/exc_vector_table.sv
module exc_vector_table #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ivpr_we_i,
    input  logic [XLEN-1:0]   ivpr_wdata_i,
    input  logic              ivor_we_i,
    input  logic [TYPE_W-1:0] ivor_idx_i,
    input  logic [XLEN-1:0]   ivor_wdata_i,
    input  logic [TYPE_W-1:0] rd_idx_i,
    output logic [XLEN-1:0]   handler_o
);
    localparam int unsigned NUM_VEC  = 1 << TYPE_W;
    localparam int unsigned OFS_LSB  = 4;
    localparam int unsigned OFS_MSB  = 15;
    localparam int unsigned PFX_LSB  = 16;

    logic [XLEN-1:0] prefix_q;
    logic [XLEN-1:0] ent_w [NUM_VEC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prefix_q <= '0;
        end else if (ivpr_we_i) begin
            prefix_q <= ivpr_wdata_i;
        end
    end

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
        logic [XLEN-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (ivor_we_i && (ivor_idx_i == TYPE_W'(g))) begin
                ent_q <= ivor_wdata_i;
            end
        end
        assign ent_w[g] = ent_q;
    end

    logic [XLEN-1:0] sel_ent;
    assign sel_ent   = ent_w[rd_idx_i];
    assign handler_o = {prefix_q[XLEN-1:PFX_LSB], sel_ent[OFS_MSB:OFS_LSB], {OFS_LSB{1'b0}}};
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit_i,
    input  exc_class_e      cls_i,
    input  logic            timer_i,
    input  logic [XLEN-1:0] cur_pc_i,
    input  logic [XLEN-1:0] next_pc_i,
    input  logic [XLEN-1:0] msr_i,
    input  logic [XLEN-1:0] tsr_i,
    input  logic [XLEN-1:0] fault_addr_i,
    input  logic [XLEN-1:0] handler_i,
    output logic [XLEN-1:0] srr0_o,
    output logic [XLEN-1:0] srr1_o,
    output logic [XLEN-1:0] msr_o,
    output logic [XLEN-1:0] tsr_o,
    output logic [XLEN-1:0] dear_o,
    output logic [XLEN-1:0] handler_o
);
    localparam logic [XLEN-1:0] KEEP = XLEN'(MSR_KEEP_MASK);
    localparam logic [XLEN-1:0] SCLR = XLEN'(MSR_SC_CLEAR);
    localparam logic [XLEN-1:0] TFLG = XLEN'(TSR_DECR_FLAG);

    logic [XLEN-1:0] ret_pc;
    logic [XLEN-1:0] new_msr;

    always_comb begin
        ret_pc  = next_pc_i;
        new_msr = msr_i & KEEP;
        unique case (cls_i)
            CLS_SYSCALL: new_msr = msr_i & ~SCLR;
            CLS_DTLB:    ret_pc  = cur_pc_i;
            CLS_ASYNC, CLS_NONE: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srr0_o    <= '0;
            srr1_o    <= '0;
            msr_o     <= '0;
            tsr_o     <= '0;
            dear_o    <= '0;
            handler_o <= '0;
        end else if (commit_i) begin
            srr0_o    <= ret_pc;
            srr1_o    <= msr_i;
            msr_o     <= new_msr;
            handler_o <= handler_i;
            if (timer_i) begin
                tsr_o <= tsr_i | TFLG;
            end
            if (cls_i == CLS_DTLB) begin
                dear_o <= fault_addr_i;
            end
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [TYPE_W-1:0] type_i,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic [XLEN-1:0]   next_pc_i,
    input  logic [XLEN-1:0]   msr_i,
    input  logic [XLEN-1:0]   tsr_i,
    input  logic [XLEN-1:0]   fault_addr_i,
    input  logic              ivpr_we_i,
    input  logic [XLEN-1:0]   ivpr_wdata_i,
    input  logic              ivor_we_i,
    input  logic [TYPE_W-1:0] ivor_idx_i,
    input  logic [XLEN-1:0]   ivor_wdata_i,
    output logic [XLEN-1:0]   srr0_o,
    output logic [XLEN-1:0]   srr1_o,
    output logic [XLEN-1:0]   msr_o,
    output logic [XLEN-1:0]   tsr_o,
    output logic [XLEN-1:0]   dear_o,
    output logic [XLEN-1:0]   handler_o,
    output logic              done_o,
    output logic              err_o
);
    exc_class_e      cls;
    logic            timer_hit;
    logic [XLEN-1:0] vec_addr;
    logic            commit;
    seq_state_e      state_q, state_d;

    exc_classify #(.TYPE_W(TYPE_W)) u_cls (
        .type_i  (type_i),
        .cls_o   (cls),
        .timer_o (timer_hit)
    );

    exc_vector_table #(.XLEN(XLEN), .TYPE_W(TYPE_W)) u_vec (
        .clk          (clk),
        .rst_n        (rst_n),
        .ivpr_we_i    (ivpr_we_i),
        .ivpr_wdata_i (ivpr_wdata_i),
        .ivor_we_i    (ivor_we_i),
        .ivor_idx_i   (ivor_idx_i),
        .ivor_wdata_i (ivor_wdata_i),
        .rd_idx_i     (type_i),
        .handler_o    (vec_addr)
    );

    assign commit = req_i && (cls != CLS_NONE);

    exc_ctx_regs #(.XLEN(XLEN)) u_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit),
        .cls_i        (cls),
        .timer_i      (timer_hit),
        .cur_pc_i     (cur_pc_i),
        .next_pc_i    (next_pc_i),
        .msr_i        (msr_i),
        .tsr_i        (tsr_i),
        .fault_addr_i (fault_addr_i),
        .handler_i    (vec_addr),
        .srr0_o       (srr0_o),
        .srr1_o       (srr1_o),
        .msr_o        (msr_o),
        .tsr_o        (tsr_o),
        .dear_o       (dear_o),
        .handler_o    (handler_o)
    );

    // Transition: any state -> ST_DONE / ST_ERR on a request, else ST_IDLE.
    always_comb begin
        state_d = ST_IDLE;
        if (req_i) begin
            state_d = (cls == CLS_NONE) ? ST_ERR : ST_DONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        done_o = 1'b0;
        err_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DONE: done_o = 1'b1;
            ST_ERR:  err_o  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned TYPE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic [TYPE_W-1:0] type_i,
    input logic [XLEN-1:0]   cur_pc_i,
    input logic [XLEN-1:0]   next_pc_i,
    input logic [XLEN-1:0]   msr_i,
    input logic [XLEN-1:0]   fault_addr_i,
    input logic [XLEN-1:0]   srr0_o,
    input logic [XLEN-1:0]   srr1_o,
    input logic [XLEN-1:0]   msr_o,
    input logic [XLEN-1:0]   tsr_o,
    input logic [XLEN-1:0]   dear_o,
    input logic [XLEN-1:0]   handler_o,
    input logic              done_o,
    input logic              err_o
);
    logic served;
    assign served = (4'(type_i) == 4'd4) || (4'(type_i) == 4'd8) ||
                    (4'(type_i) == 4'd10) || (4'(type_i) == 4'd13);

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R8
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && served) |=> done_o);

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!done_o && !err_o));

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !served) |=> (err_o && $stable(srr0_o) && $stable(msr_o) &&
                                $stable(tsr_o) && $stable(dear_o) && $stable(handler_o)));

    // R2
    ext_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && 4'(type_i) == 4'd4) |=>
            (srr0_o == $past(next_pc_i) && srr1_o == $past(msr_i) &&
             msr_o == ($past(msr_i) & 32'h0002_1200)));

    // R4
    decr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && 4'(type_i) == 4'd10) |=> tsr_o[27]);

    // R5
    dtlb_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && 4'(type_i) == 4'd13) |=>
            (srr0_o == $past(cur_pc_i) && dear_o == $past(fault_addr_i)));

    // R6
    handler_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && served) |=> (handler_o[3:0] == 4'd0));
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .TYPE_W(TYPE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .type_i       (type_i),
    .cur_pc_i     (cur_pc_i),
    .next_pc_i    (next_pc_i),
    .msr_i        (msr_i),
    .fault_addr_i (fault_addr_i),
    .srr0_o       (srr0_o),
    .srr1_o       (srr1_o),
    .msr_o        (msr_o),
    .tsr_o        (tsr_o),
    .dear_o       (dear_o),
    .handler_o    (handler_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [3:0]  type_i = '0;
    logic [31:0] cur_pc_i = '0, next_pc_i = '0, msr_i = '0, tsr_i = '0, fault_addr_i = '0;
    logic        ivpr_we_i = 1'b0, ivor_we_i = 1'b0;
    logic [31:0] ivpr_wdata_i = '0, ivor_wdata_i = '0;
    logic [3:0]  ivor_idx_i = '0;
    logic [31:0] srr0_o, srr1_o, msr_o, tsr_o, dear_o, handler_o;
    logic        done_o, err_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq u_dut (.*);

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    typedef struct {
        logic [31:0] srr0, srr1, msr, tsr, dear, hpc;
        logic        done, err;
        int          rq;
    } exp_t;
    exp_t sb_q[$];

    logic [31:0] m_srr0 = '0, m_srr1 = '0, m_msr = '0, m_tsr = '0, m_dear = '0, m_hpc = '0;
    logic [31:0] m_pfx = '0;
    logic [31:0] m_ofs [16];

    task automatic chk(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic wr_pfx(input logic [31:0] v);
        @(negedge clk); ivpr_we_i = 1'b1; ivpr_wdata_i = v;
        @(negedge clk); ivpr_we_i = 1'b0;
        m_pfx = v;
    endtask

    task automatic wr_ofs(input logic [3:0] i, input logic [31:0] v);
        @(negedge clk); ivor_we_i = 1'b1; ivor_idx_i = i; ivor_wdata_i = v;
        @(negedge clk); ivor_we_i = 1'b0;
        m_ofs[i] = v;
    endtask

    // Driver: predicts the result, pushes it, then strobes the request.
    task automatic issue(input logic [3:0] t, input logic [31:0] cpc, input logic [31:0] npc,
                         input logic [31:0] msr, input logic [31:0] tsr, input logic [31:0] fa,
                         input int rq);
        exp_t e;
        bit served;
        served = (t == 4'd4) || (t == 4'd8) || (t == 4'd10) || (t == 4'd13);
        if (served) begin
            m_srr0 = (t == 4'd13) ? cpc : npc;
            m_srr1 = msr;
            m_msr  = (t == 4'd8) ? (msr & ~32'h0002_E930) : (msr & 32'h0002_1200);
            if (t == 4'd10) m_tsr = tsr | 32'h0800_0000;
            if (t == 4'd13) m_dear = fa;
            m_hpc  = {m_pfx[31:16], m_ofs[t][15:4], 4'b0000};
        end
        e.srr0 = m_srr0; e.srr1 = m_srr1; e.msr = m_msr; e.tsr = m_tsr;
        e.dear = m_dear; e.hpc = m_hpc; e.done = served; e.err = !served; e.rq = rq;
        sb_q.push_back(e);
        @(negedge clk);
        req_i = 1'b1; type_i = t; cur_pc_i = cpc; next_pc_i = npc;
        msr_i = msr; tsr_i = tsr; fault_addr_i = fa;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    // Monitor: pops one expected item per pulse.
    always @(negedge clk) begin
        if (running) begin
            if (done_o && err_o) chk("done and err together", 8, 32'd1, 32'd0);
            if (done_o || err_o) begin
                if (sb_q.size() == 0) begin
                    chk("pulse without request", 8, 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk("done_o", 8, {31'd0, done_o}, {31'd0, e.done});
                    chk("err_o", 7, {31'd0, err_o}, {31'd0, e.err});
                    chk("srr0_o", e.rq, srr0_o, e.srr0);
                    chk("srr1_o", e.rq, srr1_o, e.srr1);
                    chk("msr_o", e.rq, msr_o, e.msr);
                    chk("tsr_o", (e.rq == 10) ? 4 : e.rq, tsr_o, e.tsr);
                    chk("dear_o", (e.rq == 13) ? 5 : e.rq, dear_o, e.dear);
                    chk("handler_o", 6, handler_o, e.hpc);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_ofs[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("reset srr0", 1, srr0_o, 0);
        chk("reset srr1", 1, srr1_o, 0);
        chk("reset msr", 1, msr_o, 0);
        chk("reset tsr", 1, tsr_o, 0);
        chk("reset dear", 1, dear_o, 0);
        chk("reset handler", 1, handler_o, 0);
        chk("reset pulses", 1, {30'd0, done_o, err_o}, 0);
        running = 1'b1;

        // R1: table reads zero before any write
        issue(4'd4, 32'h100, 32'h104, 32'hFFFF_FFFF, 32'h0, 32'h0, 1);

        // R9: load prefix and table
        wr_pfx(32'hABCD_1234);
        for (int t = 0; t < 16; t++)
            wr_ofs(4'(t), 32'hFFFF_0000 | (32'(t) << 8) | 32'h5F);

        // R2: external interrupt
        issue(4'd4, 32'h2000, 32'h2004, 32'hFFFF_FFFF, 32'h1, 32'hDEAD, 2);
        issue(4'd4, 32'h3000, 32'h3008, 32'h0002_0200, 32'h0, 32'h0, 2);
        // R3: system call
        issue(4'd8, 32'h4000, 32'h4004, 32'hFFFF_FFFF, 32'h0, 32'h0, 3);
        issue(4'd8, 32'h4100, 32'h4104, 32'h0000_16CF, 32'h0, 32'h0, 3);
        // R4: decrementer sets timer flag
        issue(4'd10, 32'h5000, 32'h5004, 32'h1234_5678, 32'h0000_0011, 32'h0, 4);
        // R5: data TLB miss
        issue(4'd13, 32'h6000, 32'h6004, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hCAFE_BABC, 5);
        // R7: unsupported types leave state alone
        issue(4'd0, 32'h7000, 32'h7004, 32'h0, 32'h0, 32'h1111, 7);
        issue(4'd5, 32'h7100, 32'h7104, 32'h0, 32'h0, 32'h2222, 7);
        issue(4'd14, 32'h7200, 32'h7204, 32'h0, 32'h0, 32'h3333, 7);
        issue(4'd15, 32'h7300, 32'h7304, 32'h0, 32'h0, 32'h4444, 7);
        // R9: rewrite an entry and the prefix, then use them
        wr_ofs(4'd8, 32'h0000_ABC7);
        wr_pfx(32'h1357_0000);
        issue(4'd8, 32'h8000, 32'h8004, 32'h0000_0000, 32'h0, 32'h0, 9);
        issue(4'd10, 32'h9000, 32'h9004, 32'h0000_FFFF, 32'h8000_0000, 32'h0, 2);

        repeat (3) @(negedge clk);
        // R8: every prediction matched by exactly one pulse
        chk("unmatched requests", 8, 32'(sb_q.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL R8 watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule